// File: doc/BRIEF.md
# Clock Input Loss-of-Signal Monitor with Restartable Validation

This block watches one clock input for missing edges. A sample-enable strobe, made elsewhere from a fixed fraction of a fast clock, tells it when to take the current input level. If the level does not change across a run of four strobes in a row, whether it is stuck high or stuck low, the block raises its loss-of-signal flag. The strobe is one clock cycle wide, and the sampled level arrives already synchronised to the block clock.

Once the flag is raised, it stays raised until the input has shown edges for a full validation window. The window is counted in strobes, and a select input chooses a short or a long window. If another run of four identical samples appears during the window, the count goes back to zero and the flag stays high. After reset the flag is high, so a clean input must first pass one full window. A chip with several reference clocks places one instance per input.

Top module: `los_validate_monitor`

## Requirements
- R1: While reset is applied and in the first cycle after it, `los_flag` is 1. The sample history is empty, so the first sample after reset starts a new run of length 1.
- R2: The strobe edge whose sample makes four consecutive sampled levels equal (all 0 or all 1) sets `los_flag` to 1, and the flag is visible right after that edge.
- R3: A sample that differs from the previous one restarts the run length at 1. A run of three equal samples followed by a different one raises no loss.
- R4: The run length saturates at four and does not wrap. Every further equal sample is another loss event, so a stuck input never clears the flag.
- R5: In cycles where `smp_en` is 0, the sampled level and `val_long` are ignored: no run advances, and neither the flag nor the validation count changes.
- R6: With `val_long` = 0 and the flag set, the flag clears at the edge of the SHORT_VALID-th consecutive strobe that carries no loss event.
- R7: With `val_long` = 1, the same clearing happens at the LONG_VALID-th such strobe.
- R8: A loss event while the flag is set keeps the flag at 1 and restarts the validation count from zero. Counting resumes at the next strobe.
- R9: Changing `val_long` during validation does not clear the count. The next strobe compares the incremented count against the newly selected length and clears the flag once count+1 reaches it or is above it.
- R10: While the flag is clear it stays clear on strobes without a loss event, whatever the level pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_en | input | 1 | One-cycle sample strobe |
| clk_level | input | 1 | Synchronised level of the monitored clock |
| val_long | input | 1 | Validation length select: 0 short, 1 long |
| los_flag | output | 1 | Loss-of-signal flag, 1 while the input is lost or not yet validated |

## Verification
The flag is a register that changes only at the edge that takes a strobe. Any set, restart or clear is therefore due in the same cycle as the strobe that causes it, and it can be seen one step after that rising edge. The bench drives every input at the falling edge and checks the flag 1 ns after the next rising edge, against a reference model that it advances at that same edge. Directed cases count out exact strobe numbers, such as the SHORT_VALID-1th and SHORT_VALID-th strobes and the strobe right after a select change, so that an off-by-one error shows up in the specific cycle where it occurs.

// File: rtl/los_pkg.sv
// Package: shared definitions for the loss-of-signal monitor.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package los_pkg;

    // Validation length choice carried on the select input.
    typedef enum logic {
        VAL_SHORT = 1'b0,
        VAL_LONG  = 1'b1
    } val_len_e;

    // Saturating increment used by the run counter.
    function automatic int unsigned sat_inc(input int unsigned v, input int unsigned max);
        return (v >= max) ? max : v + 1;
    endfunction

endpackage

// File: rtl/los_run_detect.sv
// Module: los_run_detect
// Counts consecutive equal samples of the monitored level, one per strobe,
// and flags a loss event on the strobe that makes the run reach RUN_LEN.
// Assumes: smp_en is one cycle wide; lvl is already synchronised.
module los_run_detect #(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_en,
    input  logic lvl,
    output logic loss_evt
);
    import los_pkg::*;

    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LEN);
    localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

    logic             prev_q;
    logic             hist_q;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_nx;
    logic             same;

    // Next run length: restart at one on a change, saturate when equal.
    always_comb begin
        same   = hist_q && (lvl == prev_q);
        run_nx = same ? RUN_W'(sat_inc(int'(run_q), RUN_LEN)) : RUN_ONE;
        loss_evt = smp_en && (run_nx == RUN_MAX);
    end

    // Sample history and run length, advanced only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            hist_q <= 1'b0;
            run_q  <= '0;
        end else if (smp_en) begin
            prev_q <= lvl;
            hist_q <= 1'b1;
            run_q  <= run_nx;
        end
    end

    // A differing sample restarts the run at one (R3).
    p_run_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && hist_q && (lvl != prev_q)) |=> (run_q == RUN_ONE));

    // The run never goes beyond its saturation point (R4).
    p_run_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == RUN_MAX && smp_en && lvl == prev_q) |=> (run_q == RUN_MAX));

    // Without a strobe the history is frozen (R5).
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en |=> ($stable(run_q) && $stable(prev_q)));

endmodule

// File: rtl/los_valid_timer.sv
// Module: los_valid_timer
// Counts clean strobes while the flag is set. It reports done on the strobe
// whose incremented count reaches the selected length, and it restarts from
// zero on a loss event.
// Assumes: SHORT_VALID and LONG_VALID are at least 1.
module los_valid_timer #(
    parameter int SHORT_VALID = 24,
    parameter int LONG_VALID  = 96
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_en,
    input  logic flag,
    input  logic loss_evt,
    input  logic val_long,
    output logic done
);
    import los_pkg::*;

    localparam int MAXV  = (LONG_VALID > SHORT_VALID) ? LONG_VALID : SHORT_VALID;
    localparam int CNT_W = $clog2(MAXV + 1);
    localparam logic [CNT_W-1:0] LIM_S = CNT_W'(SHORT_VALID);
    localparam logic [CNT_W-1:0] LIM_L = CNT_W'(LONG_VALID);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] limit;

    // Select the limit and decide whether this strobe finishes validation.
    always_comb begin
        limit   = (val_len_e'(val_long) == VAL_LONG) ? LIM_L : LIM_S;
        cnt_inc = cnt_q + CNT_W'(1);
        done    = smp_en && flag && !loss_evt && (cnt_inc >= limit);
    end

    // Validation count: restart on loss, clear on done, advance on clean strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (smp_en) begin
            if (!flag || loss_evt || done) cnt_q <= '0;
            else                           cnt_q <= cnt_inc;
        end
    end

    // A loss event during validation restarts the count (R8).
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && flag && loss_evt) |=> (cnt_q == '0));

    // The count stays below the longest window (R7).
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> (cnt_q < CNT_W'(MAXV)));

    // With the flag clear the count rests at zero (R10).
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && smp_en) |=> (cnt_q == '0));

endmodule

// File: rtl/los_flag_ctl.sv
// Module: los_flag_ctl
// Holds the loss-of-signal flag: it sets on a loss event and clears when
// validation is done. It is set out of reset.
// Assumes: loss_evt and done are never both 1.
module los_flag_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic loss_evt,
    input  logic done,
    output logic flag_q
);
    // Flag register: set on loss, cleared only by a finished validation.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b1;
        else if (loss_evt) flag_q <= 1'b1;
        else if (done)     flag_q <= 1'b0;
    end

    // A loss event always leaves the flag set (R2).
    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        loss_evt |=> flag_q);

    // Set and clear requests never coincide (R8).
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(loss_evt && done));

endmodule

// File: rtl/los_validate_monitor.sv
// Module: los_validate_monitor (top)
// Loss-of-signal monitor for one clock input: a run detector, a restartable
// validation timer and the flag register.
// Assumes: smp_en is a one-cycle strobe; clk_level is synchronised to clk.
module los_validate_monitor #(
    parameter int RUN_LEN     = 4,
    parameter int SHORT_VALID = 24,
    parameter int LONG_VALID  = 96
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_en,
    input  logic clk_level,
    input  logic val_long,
    output logic los_flag
);
    logic loss_evt;
    logic done;
    logic flag_q;

    // Run detector: finds RUN_LEN equal samples.
    los_run_detect #(.RUN_LEN(RUN_LEN)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_en   (smp_en),
        .lvl      (clk_level),
        .loss_evt (loss_evt)
    );

    // Validation timer: counts clean strobes against the selected window.
    los_valid_timer #(.SHORT_VALID(SHORT_VALID), .LONG_VALID(LONG_VALID)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_en   (smp_en),
        .flag     (flag_q),
        .loss_evt (loss_evt),
        .val_long (val_long),
        .done     (done)
    );

    // Flag register.
    los_flag_ctl u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .loss_evt (loss_evt),
        .done     (done),
        .flag_q   (flag_q)
    );

    assign los_flag = flag_q;

    // Without a strobe the flag never moves (R5).
    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en |=> $stable(los_flag));

    // The flag only falls on a strobe edge (R6).
    p_clear_on_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(los_flag) |-> $past(smp_en));

endmodule

// File: tb/los_validate_monitor_bench.sv
module los_validate_monitor_bench;
    localparam int SV = 24;
    localparam int LV = 96;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_en = 1'b0;
    logic clk_level = 1'b0;
    logic val_long = 1'b0;
    logic los_flag;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic cur = 1'b0;

    // Reference model state
    logic m_prev;
    bit   m_hist;
    int   m_run;
    logic m_flag;
    int   m_cnt;

    always #10 clk = ~clk;

    los_validate_monitor #(.RUN_LEN(4), .SHORT_VALID(SV), .LONG_VALID(LV)) u_los_validate_monitor (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .clk_level(clk_level),
        .val_long(val_long), .los_flag(los_flag)
    );

    function automatic int f_run(input bit hist, input logic prev, input logic lvl, input int run);
        if (hist && lvl == prev) return (run >= 4) ? 4 : run + 1;
        return 1;
    endfunction

    function automatic int f_limit(input logic sel);
        return sel ? LV : SV;
    endfunction

    task automatic model_reset();
        m_prev = 1'b0; m_hist = 1'b0; m_run = 0; m_flag = 1'b1; m_cnt = 0;
    endtask

    task automatic model_step(input logic en, input logic lvl, input logic sel);
        bit loss;
        if (!en) return;
        m_run  = f_run(m_hist, m_prev, lvl, m_run);
        m_hist = 1'b1;
        m_prev = lvl;
        loss   = (m_run == 4);
        if (m_flag) begin
            if (loss) m_cnt = 0;
            else if (m_cnt + 1 >= f_limit(sel)) begin m_flag = 1'b0; m_cnt = 0; end
            else m_cnt = m_cnt + 1;
        end else if (loss) m_flag = 1'b1;
    endtask

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s los_flag actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic en, input logic lvl, input logic sel, input string tag);
        @(negedge clk);
        smp_en = en; clk_level = lvl; val_long = sel;
        @(posedge clk);
        model_step(en, lvl, sel);
        #1;
        check(los_flag, m_flag, tag);
    endtask

    task automatic toggle_n(input int n, input logic sel, input string tag);
        for (int i = 0; i < n; i++) begin
            cur = ~cur;
            step(1'b1, cur, sel, tag);
        end
    endtask

    task automatic hold_n(input int n, input logic sel, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, cur, sel, tag);
    endtask

    initial begin : main
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        model_reset();
        repeat (3) @(posedge clk);
        #1; check(los_flag, 1'b1, "R1 during reset");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check(los_flag, 1'b1, "R1 after reset");

        // R6: short validation from reset
        cur = 1'b0;
        toggle_n(SV - 1, 1'b0, "R6 before window end");
        check(los_flag, 1'b1, "R6 flag held at SV-1");
        toggle_n(1, 1'b0, "R6 window end");
        check(los_flag, 1'b0, "R6 cleared at SV");

        // R5: no strobe, constant level
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b1, "R5 no strobe");
        check(los_flag, 1'b0, "R5 still clear");

        // R3: runs of three
        cur = 1'b0;
        toggle_n(1, 1'b0, "R3 lead");
        hold_n(2, 1'b0, "R3 run of three");
        toggle_n(1, 1'b0, "R3 break");
        hold_n(2, 1'b0, "R3 run of three");
        toggle_n(1, 1'b0, "R3 break");
        check(los_flag, 1'b0, "R3 no loss from runs of three");

        // R2: all-zero run of four
        toggle_n(1, 1'b0, "R2 lead");
        if (cur != 1'b0) toggle_n(1, 1'b0, "R2 lead");
        hold_n(2, 1'b0, "R2 three zeros");
        check(los_flag, 1'b0, "R2 not yet at three");
        hold_n(1, 1'b0, "R2 fourth zero");
        check(los_flag, 1'b1, "R2 set on fourth equal sample");

        // R4: stuck input keeps the flag set
        hold_n(30, 1'b0, "R4 stuck low saturates");
        check(los_flag, 1'b1, "R4 still set");
        toggle_n(SV - 1, 1'b0, "R6 recover");
        check(los_flag, 1'b1, "R6 held at SV-1");
        toggle_n(1, 1'b0, "R6 recover end");
        check(los_flag, 1'b0, "R6 cleared");

        // R2 all-ones, R8 restart
        if (cur != 1'b1) toggle_n(1, 1'b0, "R2 lead");
        hold_n(3, 1'b0, "R2 four ones");
        check(los_flag, 1'b1, "R2 set by all ones");
        toggle_n(10, 1'b0, "R8 partial window");
        hold_n(3, 1'b0, "R8 new loss during window");
        check(los_flag, 1'b1, "R8 flag kept");
        toggle_n(SV - 1, 1'b0, "R8 restarted window");
        check(los_flag, 1'b1, "R8 count restarted from zero");
        toggle_n(1, 1'b0, "R8 window end");
        check(los_flag, 1'b0, "R8 clears after full fresh window");

        // R7: long window
        hold_n(4, 1'b1, "R7 loss");
        check(los_flag, 1'b1, "R7 set");
        toggle_n(LV - 1, 1'b1, "R7 long window");
        check(los_flag, 1'b1, "R7 held at LV-1");
        toggle_n(1, 1'b1, "R7 long end");
        check(los_flag, 1'b0, "R7 cleared at LV");

        // R9: long to short after 30 clean strobes
        hold_n(4, 1'b1, "R9 loss");
        toggle_n(30, 1'b1, "R9 long count");
        check(los_flag, 1'b1, "R9 still set under long");
        toggle_n(1, 1'b0, "R9 switch to short");
        check(los_flag, 1'b0, "R9 count kept, clears at next comparison");

        // R9: short to long after 10 clean strobes
        hold_n(4, 1'b0, "R9 loss");
        toggle_n(10, 1'b0, "R9 short count");
        toggle_n(LV - 11, 1'b1, "R9 continue under long");
        check(los_flag, 1'b1, "R9 held at LV-1 total");
        toggle_n(1, 1'b1, "R9 long end");
        check(los_flag, 1'b0, "R9 cleared at LV total");

        // R10 and mixed: random stimulus against the model
        for (int ph = 0; ph < 4; ph++) begin
            for (int i = 0; i < 2500; i++) begin
                logic en, lvl, sel;
                en  = ($urandom_range(0, 2) != 0);
                lvl = ($urandom_range(0, 5 - ph) != 0) ? ~cur : cur;
                sel = (ph >= 2) ? logic'($urandom_range(0, 15) == 0) ^ val_long : 1'b0;
                if (en) cur = lvl;
                step(en, lvl, sel, m_flag ? "R8 random validation" : "R10 random clear");
            end
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule